// File: doc/BRIEF.md
# DS3 Path Performance Counters

This block accumulates two performance-monitoring counts for a DS3 receiver that runs the C-bit parity framing format. Once per received M-frame an upstream framer raises a one-cycle strobe. With that strobe it presents the three path-parity (CP) bits, the three far-end block error (FEBE) bits, the parity it computed over the previous M-frame's payload, an out-of-frame flag, the framing mode and a control bit. The block judges the frame and bumps one or both internal 16-bit tallies.

Software sees only snapshots. An update pulse, usually driven by a one-second tick, copies both live tallies into holding registers and restarts the live tallies in the same cycle. The host reads the snapshots one byte at a time through a small address/data read port. The live tallies stop at full scale instead of wrapping. They do not move when the framing mode is M23 DS3 or E3, because these counts carry no meaning in those modes.

Top module: `ds3_pm_counters`

## Requirements
- R1: After reset both holding registers read 0 at all four byte addresses.
- R2: The read port returns only the values captured at the most recent update pulse. Events counted since then do not appear until the next pulse.
- R3: On a strobe in C-bit mode, the parity count increments when the majority of the CP bits disagrees with `calc_parity`. The majority is 1 when two or more of the three bits are 1, and 0 otherwise.
- R4: On a strobe in C-bit mode, the FEBE count increments when `febe_bits` is any value other than 3'b111.
- R5: While `oof` is 1, both counts hold if `count_in_oof` is 0 and keep counting if it is 1.
- R6: Neither count changes when `mode` is 2'b01 (M23 DS3) or 2'b10 (E3). Counting happens only when `mode` is 2'b00 (C-bit DS3).
- R7: An update pulse copies each live count into its holding register and restarts the live count in that cycle. An event in the same cycle is excluded from the copied value and starts the new interval at 1.
- R8: Each live count saturates at 16'hFFFF and never wraps to 0.
- R9: Read byte map on `rd_addr`: 0 is parity count bits 7:0, 1 is parity count bits 15:8, 2 is FEBE count bits 7:0, 3 is FEBE count bits 15:8. `rd_data` is combinational from `rd_addr`.
- R10: Each count grows by at most one per strobe cycle and never changes in a cycle without a strobe, apart from the restart on an update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mframe_stb | input | 1 | One-cycle marker that the frame inputs are valid |
| cp_bits | input | 3 | The three received CP bits |
| febe_bits | input | 3 | The three received FEBE bits |
| calc_parity | input | 1 | Locally computed parity over the previous M-frame |
| oof | input | 1 | Receiver is out of frame |
| mode | input | 2 | 00 C-bit DS3, 01 M23 DS3, 10 E3 |
| count_in_oof | input | 1 | 1 keeps counting while out of frame |
| snap | input | 1 | Update pulse: latch the counts and restart them |
| rd_addr | input | 2 | Byte select for the read port |
| rd_data | output | 8 | Selected byte of a holding register |

## Verification
A corrupted live tally does not show at the ports until the next update pulse. At that pulse it appears as a wrong byte at address 0 to 3, so the bench snapshots after every scenario and compares both counts at once. A bad qualification term, such as mode, out-of-frame or the majority vote, shows as an off-by-N snapshot after one interval. A bad restart shows one interval later, as a stale count or a dropped event in the follow-up snapshot. Saturation and byte ordering show only at full-scale or asymmetric counts, so those are driven on purpose.

// File: rtl/ds3_pm_counters.sv
module ds3_pm_counters #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mframe_stb,
  input  logic [2:0] cp_bits,
  input  logic [2:0] febe_bits,
  input  logic       calc_parity,
  input  logic       oof,
  input  logic [1:0] mode,
  input  logic       count_in_oof,
  input  logic       snap,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [CNT_W-1:0] FULL      = '1;
  localparam logic [1:0]       MODE_CBIT = 2'b00;

  logic [CNT_W-1:0] cp_live, fe_live, cp_hold, fe_hold;

  wire cp_vote = (cp_bits[0] & cp_bits[1]) | (cp_bits[0] & cp_bits[2]) | (cp_bits[1] & cp_bits[2]);
  wire armed   = mframe_stb && (mode == MODE_CBIT) && (!oof || count_in_oof);
  wire cp_hit  = armed && (cp_vote != calc_parity);
  wire fe_hit  = armed && (febe_bits != 3'b111);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic hit);
    return (hit && v != FULL) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_live <= '0;
      fe_live <= '0;
      cp_hold <= '0;
      fe_hold <= '0;
    end else if (snap) begin
      cp_hold <= cp_live;
      fe_hold <= fe_live;
      cp_live <= {{(CNT_W-1){1'b0}}, cp_hit};
      fe_live <= {{(CNT_W-1){1'b0}}, fe_hit};
    end else begin
      cp_live <= bump(cp_live, cp_hit);
      fe_live <= bump(fe_live, fe_hit);
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cp_hold[7:0];
      2'd1:    rd_data = cp_hold[15:8];
      2'd2:    rd_data = fe_hold[7:0];
      default: rd_data = fe_hold[15:8];
    endcase
  end
endmodule

module ds3_pm_counters_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mframe_stb,
  input logic             snap,
  input logic             oof,
  input logic             count_in_oof,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cp_live,
  input logic [CNT_W-1:0] fe_live,
  input logic [CNT_W-1:0] cp_hold,
  input logic [CNT_W-1:0] fe_hold
);
  localparam logic [CNT_W-1:0] FULL = '1;

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(cp_hold) && $stable(fe_hold));

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (cp_live <= 1) && (fe_live <= 1));

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> cp_hold == $past(cp_live) && fe_hold == $past(fe_live));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_live == FULL) && !snap |=> cp_live == FULL);

  a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) && !snap |=> $stable(cp_live) && $stable(fe_live));

  a_r5_oof_hold: assert property (@(posedge clk) disable iff (!rst_n)
    oof && !count_in_oof && !snap |=> $stable(cp_live) && $stable(fe_live));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mframe_stb && !snap |=> $stable(cp_live) && $stable(fe_live));

  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> (cp_live - $past(cp_live)) <= 1 && (fe_live - $past(fe_live)) <= 1);
endmodule

bind ds3_pm_counters ds3_pm_counters_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mframe_stb(mframe_stb), .snap(snap), .oof(oof),
  .count_in_oof(count_in_oof), .mode(mode), .cp_live(cp_live), .fe_live(fe_live),
  .cp_hold(cp_hold), .fe_hold(fe_hold)
);

// File: tb/tb_ds3_pm_counters.sv
module tb_ds3_pm_counters;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       mframe_stb = 0;
  logic [2:0] cp_bits = 3'b000;
  logic [2:0] febe_bits = 3'b111;
  logic       calc_parity = 0;
  logic       oof = 0;
  logic [1:0] mode = 2'b00;
  logic       count_in_oof = 0;
  logic       snap = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ds3_pm_counters dut (.*);

  task automatic chk8(input [1:0] a, input [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_counts(input [15:0] cp, input [15:0] fe, input string req);
    chk8(2'd0, cp[7:0], req);
    chk8(2'd1, cp[15:8], req);
    chk8(2'd2, fe[7:0], req);
    chk8(2'd3, fe[15:8], req);
  endtask

  task automatic frame(input [2:0] cp, input [2:0] fe, input par, input int n);
    @(negedge clk);
    cp_bits = cp; febe_bits = fe; calc_parity = par; mframe_stb = 1;
    repeat (n) @(negedge clk);
    mframe_stb = 0; cp_bits = 3'b000; febe_bits = 3'b111; calc_parity = 0;
  endtask

  task automatic do_snap();
    @(negedge clk);
    snap = 1;
    @(negedge clk);
    snap = 0;
  endtask

  task automatic t_reset();
    chk_counts(16'd0, 16'd0, "R1");
  endtask

  task automatic t_cp_vote();
    do_snap();
    frame(3'b000, 3'b111, 0, 1);
    frame(3'b001, 3'b111, 0, 1);
    frame(3'b100, 3'b111, 0, 1);
    frame(3'b011, 3'b111, 0, 1);
    frame(3'b101, 3'b111, 0, 1);
    frame(3'b110, 3'b111, 0, 1);
    frame(3'b111, 3'b111, 0, 1);
    frame(3'b000, 3'b111, 1, 1);
    frame(3'b010, 3'b111, 1, 1);
    frame(3'b111, 3'b111, 1, 1);
    chk_counts(16'd0, 16'd0, "R2 live not visible");
    do_snap();
    chk_counts(16'd6, 16'd0, "R3 majority vote");
  endtask

  task automatic t_febe();
    frame(3'b000, 3'b000, 0, 1);
    frame(3'b000, 3'b110, 0, 1);
    frame(3'b000, 3'b011, 0, 1);
    frame(3'b000, 3'b111, 0, 1);
    frame(3'b000, 3'b101, 0, 1);
    do_snap();
    chk_counts(16'd0, 16'd4, "R4 febe");
  endtask

  task automatic t_oof();
    oof = 1; count_in_oof = 0;
    frame(3'b111, 3'b000, 0, 3);
    do_snap();
    chk_counts(16'd0, 16'd0, "R5 oof hold");
    count_in_oof = 1;
    frame(3'b111, 3'b000, 0, 2);
    do_snap();
    chk_counts(16'd2, 16'd2, "R5 oof count");
    oof = 0; count_in_oof = 0;
  endtask

  task automatic t_modes();
    mode = 2'b01;
    frame(3'b111, 3'b000, 0, 2);
    mode = 2'b10;
    frame(3'b111, 3'b000, 0, 2);
    do_snap();
    chk_counts(16'd0, 16'd0, "R6 m23/e3 no count");
    mode = 2'b00;
    frame(3'b111, 3'b000, 0, 1);
    do_snap();
    chk_counts(16'd1, 16'd1, "R6 cbit counts");
  endtask

  task automatic t_same_cycle();
    frame(3'b111, 3'b000, 0, 3);
    @(negedge clk);
    cp_bits = 3'b111; febe_bits = 3'b000; calc_parity = 0; mframe_stb = 1; snap = 1;
    @(negedge clk);
    mframe_stb = 0; snap = 0; cp_bits = 3'b000; febe_bits = 3'b111;
    chk_counts(16'd3, 16'd3, "R7 capture excludes event");
    do_snap();
    chk_counts(16'd1, 16'd1, "R7 event starts new interval");
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    cp_bits = 3'b111; febe_bits = 3'b000;
    repeat (10) @(negedge clk);
    cp_bits = 3'b000; febe_bits = 3'b111;
    do_snap();
    chk_counts(16'd0, 16'd0, "R10 no strobe");
  endtask

  task automatic t_bytes();
    frame(3'b111, 3'b111, 0, 300);
    frame(3'b000, 3'b010, 0, 5);
    do_snap();
    chk_counts(16'h012C, 16'h0005, "R9 byte map");
  endtask

  task automatic t_saturate();
    frame(3'b111, 3'b000, 0, 65540);
    do_snap();
    chk_counts(16'hFFFF, 16'hFFFF, "R8 saturate");
    do_snap();
    chk_counts(16'd0, 16'd0, "R7 restart after full");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_cp_vote();
    t_febe();
    t_oof();
    t_modes();
    t_same_cycle();
    t_no_strobe();
    t_bytes();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual hung expected done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule